// File: doc/BRIEF.md
# Configuration Register Bank with Pin Routing

This block is a byte-wide bank of control registers behind a plain register port: an 8-bit address, 8-bit write data, a write strobe and a combinational read-data output. It stores the device address the serial management bus answers to, a control byte with an analog-output disable bit and a self-clearing software reset, a configuration byte for one general-purpose pin, and a one-bit general-purpose output value that the pin can carry.

The pin configuration chooses which internal status signal drives the pin: the output register bit, a clock-loss flag, a clock-present flag or a power-on-reset flag. It also drives the pin's output enable, its input-buffer enable and the pull-up and pull-down controls. A separate comparator flags when an incoming 7-bit bus address equals the stored device address. The register port has no back-pressure: every write is taken on the edge where the strobe is high, and no stream interface exists at the block's edge. Status inputs are plain levels and reach the pin output through combinational logic only.

Top module: `cfg_regbank`

## Requirements
- R1: After hardware reset (rst_n low) the bank reads 0xAE at address 0x00, 0x00 at 0x01, 0x05 at 0x02 and 0x00 at 0x03.
- R2: A write to 0x00 stores write-data bits 7:1 as the device address; reading 0x00 returns that address in bits 7:1 with bit 0 always 0.
- R3: addr_match is high exactly when bus_addr equals the stored 7-bit device address.
- R4: Address 0x01 bit 4 drives analog_dis directly; bits 7:5 and 3:1 of 0x01 read 0 whatever was written.
- R5: A write with bit 0 of 0x01 set makes 0x01 read back the written bit 0 and bit 4 until the next edge; on that next edge registers 0x01, 0x02 and 0x03 return to their reset values, 0x01 bit 0 reads 0 from then on, and writes to 0x01..0x03 presented in that cycle are discarded.
- R6: The software reset leaves the device address at 0x00 unchanged.
- R7: 0x02 bits 7:4 pick the pin_out source: 0000 = bit 0 of register 0x03, 0011 = clk_loss, 0100 = clk_detect, 0110 = por_flag; every other code drives pin_out to 0.
- R8: 0x02 bits 3:2 set the pulls: 00 neither, 01 pull_dn_en only, 10 pull_up_en only, 11 neither.
- R9: 0x02 bit 1 drives pin_ie and bit 0 drives pin_oe.
- R10: Reads of addresses 0x04 to 0xFF return 0x00 and writes to them change no register; register 0x03 reads 0 in bits 7:1.
- R11: reg_rdata reflects reg_addr in the same cycle, and a write is visible on reg_rdata from the edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, restores every register |
| reg_addr | input | 8 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one write per edge |
| reg_rdata | output | 8 | Combinational read data |
| bus_addr | input | 7 | Incoming serial-bus address to compare |
| addr_match | output | 1 | High when bus_addr equals the stored device address |
| clk_loss | input | 1 | Clock-loss status flag |
| clk_detect | input | 1 | Clock-present status flag |
| por_flag | input | 1 | Power-on-reset status flag |
| analog_dis | output | 1 | Analog output disable |
| pin_out | output | 1 | Selected pin output value |
| pin_oe | output | 1 | Pin output enable |
| pin_ie | output | 1 | Pin input-buffer enable |
| pull_up_en | output | 1 | Pull-up enable |
| pull_dn_en | output | 1 | Pull-down enable |

## Verification
Register contents, analog_dis, the pin enables and the pull controls change on the clock edge that takes a write, so the bench writes on a falling edge and reads at the next falling edge; pin_out, addr_match and reg_rdata follow their inputs within the same cycle, so the bench settles those inputs for one time step and samples without any clock edge in between. The software reset is the one two-edge result: the bench reads the control byte in the cycle right after the write, when the set bit must still show, and again after the following edge, when the defaults must be back. Pin modes, status patterns, pull codes and bus addresses are swept in full.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int DEV_AW    = 7;
  localparam int MODE_W    = 4;

  localparam logic [ADDR_W-1:0] A_DEVID  = 8'h00;
  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h01;
  localparam logic [ADDR_W-1:0] A_PINCFG = 8'h02;
  localparam logic [ADDR_W-1:0] A_GPOUT  = 8'h03;

  localparam int CTRL_SRST_BIT   = 0;
  localparam int CTRL_ANALOG_BIT = 4;

  typedef enum logic [MODE_W-1:0] {
    SRC_GPREG   = 4'b0000,
    SRC_CLKLOSS = 4'b0011,
    SRC_CLKDET  = 4'b0100,
    SRC_POR     = 4'b0110
  } pin_src_e;

  typedef enum logic [1:0] {
    PULL_NONE = 2'b00,
    PULL_DOWN = 2'b01,
    PULL_UP   = 2'b10,
    PULL_RSVD = 2'b11
  } pull_e;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    pull_e             pull;
    logic              in_en;
    logic              out_en;
  } pin_cfg_t;

  localparam pin_cfg_t PIN_CFG_RST = '{
    mode:   4'b0000,
    pull:   PULL_DOWN,
    in_en:  1'b0,
    out_en: 1'b1
  };

endpackage

// File: rtl/cfg_devaddr_reg.sv
module cfg_devaddr_reg
  import cfgbank_pkg::*;
#(
  parameter logic [DEV_AW-1:0] RST_ADDR = 7'h57
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DEV_AW-1:0] wr_addr,
  input  logic [DEV_AW-1:0] bus_addr,
  output logic [DEV_AW-1:0] dev_addr,
  output logic              addr_match
);

  // Only the hardware reset reaches this register; the soft reset does not.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dev_addr <= RST_ADDR;
    else if (wr_en) dev_addr <= wr_addr;
  end

  assign addr_match = (bus_addr == dev_addr);

  a_r3_match_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (addr_match == (bus_addr == $past(wr_addr))));

endmodule

// File: rtl/cfg_ctrl_reg.sv
module cfg_ctrl_reg
  import cfgbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_analog,
  input  logic              wr_srst,
  output logic              analog_dis,
  output logic              srst_pulse,
  output logic [DATA_W-1:0] rdata
);

  logic srst_pend;

  // A set reset bit lives for one cycle; the following edge restores defaults.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      analog_dis <= 1'b0;
      srst_pend  <= 1'b0;
    end else if (srst_pend) begin
      analog_dis <= 1'b0;
      srst_pend  <= 1'b0;
    end else if (wr_en) begin
      analog_dis <= wr_analog;
      srst_pend  <= wr_srst;
    end
  end

  assign srst_pulse = srst_pend;

  always_comb begin
    rdata                  = '0;
    rdata[CTRL_ANALOG_BIT] = analog_dis;
    rdata[CTRL_SRST_BIT]   = srst_pend;
  end

  a_r5_srst_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pend |=> !srst_pend);

  a_r5_analog_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pend |=> !analog_dis);

endmodule

// File: rtl/cfg_pin_ctrl.sv
module cfg_pin_ctrl
  import cfgbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              gp_we,
  input  logic              gp_wbit,
  input  logic              clk_loss,
  input  logic              clk_detect,
  input  logic              por_flag,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [DATA_W-1:0] gp_rdata,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              pin_ie,
  output logic              pull_up_en,
  output logic              pull_dn_en
);

  pin_cfg_t cfg_q;
  logic     gp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= PIN_CFG_RST;
      gp_q  <= 1'b0;
    end else if (soft_rst) begin
      cfg_q <= PIN_CFG_RST;
      gp_q  <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= pin_cfg_t'(cfg_wdata);
      if (gp_we)  gp_q  <= gp_wbit;
    end
  end

  // Source selection; reserved codes park the pin low.
  always_comb begin
    case (pin_src_e'(cfg_q.mode))
      SRC_GPREG:   pin_out = gp_q;
      SRC_CLKLOSS: pin_out = clk_loss;
      SRC_CLKDET:  pin_out = clk_detect;
      SRC_POR:     pin_out = por_flag;
      default:     pin_out = 1'b0;
    endcase
  end

  always_comb begin
    pull_up_en = 1'b0;
    pull_dn_en = 1'b0;
    case (cfg_q.pull)
      PULL_UP:   pull_up_en = 1'b1;
      PULL_DOWN: pull_dn_en = 1'b1;
      default:   ;
    endcase
  end

  assign pin_oe    = cfg_q.out_en;
  assign pin_ie    = cfg_q.in_en;
  assign cfg_rdata = cfg_q;
  assign gp_rdata  = {{(DATA_W-1){1'b0}}, gp_q};

  a_r8_pulls_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pull_up_en && pull_dn_en));

  a_r7_gp_follows_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[7:4] == 4'b0000) |-> (pin_out == gp_rdata[0]));

  a_r5_pin_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (pin_oe && !pin_ie && pull_dn_en && !pull_up_en && gp_rdata == '0));

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfgbank_pkg::*;
#(
  parameter logic [DEV_AW-1:0] DEV_ADDR_DEFAULT = 7'h57
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DEV_AW-1:0] bus_addr,
  output logic              addr_match,
  input  logic              clk_loss,
  input  logic              clk_detect,
  input  logic              por_flag,
  output logic              analog_dis,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              pin_ie,
  output logic              pull_up_en,
  output logic              pull_dn_en
);

  logic              we_dev, we_ctrl, we_pin, we_gp;
  logic              srst_pulse;
  logic [DEV_AW-1:0] dev_addr;
  logic [DATA_W-1:0] ctrl_rdata, pin_rdata, gp_rdata;

  assign we_dev  = reg_we && (reg_addr == A_DEVID);
  assign we_ctrl = reg_we && (reg_addr == A_CTRL);
  assign we_pin  = reg_we && (reg_addr == A_PINCFG);
  assign we_gp   = reg_we && (reg_addr == A_GPOUT);

  cfg_devaddr_reg #(.RST_ADDR(DEV_ADDR_DEFAULT)) u_dev (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (we_dev),
    .wr_addr    (reg_wdata[DATA_W-1:1]),
    .bus_addr   (bus_addr),
    .dev_addr   (dev_addr),
    .addr_match (addr_match)
  );

  cfg_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (we_ctrl),
    .wr_analog  (reg_wdata[CTRL_ANALOG_BIT]),
    .wr_srst    (reg_wdata[CTRL_SRST_BIT]),
    .analog_dis (analog_dis),
    .srst_pulse (srst_pulse),
    .rdata      (ctrl_rdata)
  );

  cfg_pin_ctrl u_pin (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (srst_pulse),
    .cfg_we     (we_pin),
    .cfg_wdata  (reg_wdata),
    .gp_we      (we_gp),
    .gp_wbit    (reg_wdata[0]),
    .clk_loss   (clk_loss),
    .clk_detect (clk_detect),
    .por_flag   (por_flag),
    .cfg_rdata  (pin_rdata),
    .gp_rdata   (gp_rdata),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .pin_ie     (pin_ie),
    .pull_up_en (pull_up_en),
    .pull_dn_en (pull_dn_en)
  );

  always_comb begin
    case (reg_addr)
      A_DEVID:  reg_rdata = {dev_addr, 1'b0};
      A_CTRL:   reg_rdata = ctrl_rdata;
      A_PINCFG: reg_rdata = pin_rdata;
      A_GPOUT:  reg_rdata = gp_rdata;
      default:  reg_rdata = '0;
    endcase
  end

  a_r2_devid_lsb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_DEVID) |-> (reg_rdata[0] == 1'b0));

  a_r6_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_pulse && !we_dev) |=> $stable(dev_addr));

  a_r4_ctrl_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CTRL) |-> (reg_rdata[7:5] == 3'b000 && reg_rdata[3:1] == 3'b000));

endmodule

// File: tb/tb_cfg_regbank.sv
module tb_cfg_regbank;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_rdata;
  logic [6:0] bus_addr = '0;
  logic       addr_match;
  logic       clk_loss = 0, clk_detect = 0, por_flag = 0;
  logic       analog_dis, pin_out, pin_oe, pin_ie, pull_up_en, pull_dn_en;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cfg_regbank dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .bus_addr(bus_addr),
    .addr_match(addr_match), .clk_loss(clk_loss), .clk_detect(clk_detect),
    .por_flag(por_flag), .analog_dis(analog_dis), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_ie(pin_ie), .pull_up_en(pull_up_en),
    .pull_dn_en(pull_dn_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a; reg_we = 1'b0;
    #1 d = reg_rdata;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(8'h00, v); check("R1 devid", v, 8'hAE);
    rd(8'h01, v); check("R1 ctrl", v, 8'h00);
    rd(8'h02, v); check("R1 pincfg", v, 8'h05);
    rd(8'h03, v); check("R1 gpout", v, 8'h00);
    check("R9 oe reset", pin_oe, 1); check("R9 ie reset", pin_ie, 0);
    check("R8 pulldown reset", {pull_up_en, pull_dn_en}, 2'b01);

    // R2 / R11 device address writes, bit 0 written as 1
    for (int a = 0; a < 128; a += 9) begin
      wr(8'h00, {a[6:0], 1'b1});
      rd(8'h00, v); check("R2 R11 devid readback", v, {a[6:0], 1'b0});
    end

    // R3 full sweep for two stored addresses
    foreach (v[i]) ;
    for (int s = 0; s < 2; s++) begin
      logic [6:0] stored;
      stored = (s == 0) ? 7'h2A : 7'h7F;
      wr(8'h00, {stored, 1'b0});
      for (int b = 0; b < 128; b++) begin
        bus_addr = b[6:0];
        #1 check("R3 match", addr_match, (b[6:0] == stored));
      end
    end

    // R4 analog bit and reserved bits
    wr(8'h01, 8'hFE);
    rd(8'h01, v); check("R4 ctrl reserved", v, 8'h10);
    check("R4 analog_dis set", analog_dis, 1);
    wr(8'h01, 8'hEE);
    check("R4 analog_dis clear", analog_dis, 0);

    // R7 mode sweep against status patterns and gp bit
    for (int m = 0; m < 16; m++) begin
      for (int g = 0; g < 2; g++) begin
        wr(8'h03, {7'h7F, g[0]});
        wr(8'h02, {m[3:0], 4'b0101});
        for (int st = 0; st < 8; st++) begin
          logic e;
          {clk_loss, clk_detect, por_flag} = st[2:0];
          case (m)
            0: e = g[0];
            3: e = st[2];
            4: e = st[1];
            6: e = st[0];
            default: e = 1'b0;
          endcase
          #1 check("R7 pin_out", pin_out, e);
        end
      end
    end
    rd(8'h03, v); check("R10 gpout upper bits", v, 8'h01);

    // R8 / R9 pull codes and enables
    for (int c = 0; c < 16; c++) begin
      logic [1:0] pe;
      wr(8'h02, {4'b0000, c[3:0]});
      case (c[3:2]) 2'b01: pe = 2'b01; 2'b10: pe = 2'b10; default: pe = 2'b00; endcase
      check("R8 pulls", {pull_up_en, pull_dn_en}, pe);
      check("R9 ie", pin_ie, c[1]);
      check("R9 oe", pin_oe, c[0]);
    end

    // R10 unmapped addresses
    wr(8'h00, 8'h64); wr(8'h01, 8'h10); wr(8'h02, 8'h3A); wr(8'h03, 8'h01);
    for (int a = 4; a < 256; a++) begin
      wr(a[7:0], 8'hFF);
      rd(a[7:0], v); check("R10 unmapped read", v, 8'h00);
    end
    rd(8'h00, v); check("R10 devid kept", v, 8'h64);
    rd(8'h01, v); check("R10 ctrl kept", v, 8'h10);
    rd(8'h02, v); check("R10 pincfg kept", v, 8'h3A);
    rd(8'h03, v); check("R10 gpout kept", v, 8'h01);

    // R5 / R6 software reset, with a write to 0x02 in the pending cycle
    wr(8'h01, 8'h11);
    rd(8'h01, v); check("R5 pending readback", v, 8'h11);
    check("R5 analog while pending", analog_dis, 1);
    reg_addr = 8'h02; reg_wdata = 8'hF0; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    rd(8'h01, v); check("R5 ctrl after reset", v, 8'h00);
    rd(8'h02, v); check("R5 pincfg defaults", v, 8'h05);
    rd(8'h03, v); check("R5 gpout defaults", v, 8'h00);
    check("R5 analog cleared", analog_dis, 0);
    rd(8'h00, v); check("R6 devid survives", v, 8'h64);
    @(negedge clk);
    rd(8'h01, v); check("R5 stays clear", v, 8'h00);

    // R1 hardware reset restores device address too
    rst_n = 1'b0; #2 rst_n = 1'b1;
    @(negedge clk);
    rd(8'h00, v); check("R1 devid after hw reset", v, 8'hAE);

    done = 1;
    finish_run();
  end

endmodule